// File: doc/BRIEF.md
# Sync-Bit Clock Correction Counter

This block counts the sync-bit strobes of one chosen Manchester decoder over a fixed number of periods of a 32 kHz reference. The count is a measure of the decoder's bit rate against the reference, and software reads it to judge how far a local clock has drifted. A write of a select code picks the decoder and starts a measurement. While the measurement runs, the result reads zero. When the window ends, the result takes the final count and holds it until the next start.

The control is a two-state machine. In state `ST_IDLE` the result holds its last value. The transition *start* (a select write with a code other than all-ones) leads from either state to `ST_MEASURE`; from `ST_MEASURE` it acts as a *restart*. From `ST_MEASURE`, the transition *abort* (a select write of the all-ones code) and the transition *window end* (the last reference tick of the window) both lead back to `ST_IDLE`. If a start and a window end fall in the same cycle, the start wins.

Top module: `sync_corr_counter`

## Requirements
- R1: The window spans 2^WIN_LOG2 pulses of `tick_ref` counted after the start. The result is loaded on the clock edge that samples the last of those pulses.
- R2: Select code 0, 1 or 2 counts only strobes on bit 0, 1 or 2 of `sync_strb`. Strobes on the other bits have no effect on the result.
- R3: A write (`sel_wr` high) of any code other than 3 (all ones) starts a measurement, and `corr_value` is 0 after that edge.
- R4: `corr_value` stays 0 for every cycle of a running measurement.
- R5: After reset, `corr_value` is 0 and no measurement runs.
- R6: A write of code 3 during a measurement aborts it. `corr_value` then stays 0, and later ticks and strobes do not update it.
- R7: A write of a code other than 3 during a measurement restarts both the window and the count. Strobes and ticks seen before the restart are discarded.
- R8: While idle, a write of code 3, reference ticks and strobes all leave `corr_value` unchanged.
- R9: The count saturates at 2^RES_W-1 and does not wrap.
- R10: The count includes a strobe in the same cycle as the last tick of the window. It excludes a strobe in the cycle of the starting write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_wr | input | 1 | One-cycle write strobe for the select code |
| sel_code | input | SEL_W | Decoder select; all ones requests disable |
| tick_ref | input | 1 | One-cycle pulse per 32 kHz reference period |
| sync_strb | input | NUM_DEC | Sync-bit detect strobes, one per decoder |
| corr_value | output | RES_W | Measurement result, 0 while busy |

## Verification
The bench builds the block with WIN_LOG2 = 3 and RES_W = 5. An eight-tick window is short enough to sweep every decoder select against four tick spacings and three strobe phases. A 5-bit result lets a window with a strobe in every cycle run past the saturation point of 31. The directed cases that follow place a strobe exactly on the last tick and on the starting write, and they restart or abort partway through a window.

// File: rtl/sync_corr_pkg.sv
package sync_corr_pkg;
    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_MEASURE = 1'b1
    } corr_state_e;
endpackage

// File: rtl/sc_sat_counter.sv
module sc_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] val,
    output logic [W-1:0] val_nxt
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] val_q;

    assign val_nxt = (inc && (val_q != TOP)) ? val_q + 1'b1 : val_q;
    assign val     = val_q;

    always_ff @(posedge clk) begin
        if (!rst_n)   val_q <= '0;
        else if (clr) val_q <= '0;
        else          val_q <= val_nxt;
    end

    // R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (val_q == TOP && !clr) |=> (val_q == TOP));
endmodule

// File: rtl/sc_window_timer.sv
module sc_window_timer #(
    parameter int WIN_LOG2 = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic tick,
    output logic last
);
    localparam logic [WIN_LOG2-1:0] TOP = {WIN_LOG2{1'b1}};

    logic [WIN_LOG2-1:0] cnt_q;

    assign last = run && tick && (cnt_q == TOP);

    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (clr)         cnt_q <= '0;
        else if (run && tick) cnt_q <= cnt_q + 1'b1;
    end

    // R1
    window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(run && tick)) |=> $stable(cnt_q));
endmodule

// File: rtl/sync_corr_counter.sv
module sync_corr_counter
    import sync_corr_pkg::*;
#(
    parameter int NUM_DEC  = 3,
    parameter int SEL_W    = 2,
    parameter int WIN_LOG2 = 9,
    parameter int RES_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_wr,
    input  logic [SEL_W-1:0]   sel_code,
    input  logic               tick_ref,
    input  logic [NUM_DEC-1:0] sync_strb,
    output logic [RES_W-1:0]   corr_value
);
    localparam int             SEL_N   = 1 << SEL_W;
    localparam logic [SEL_W-1:0] SEL_OFF = {SEL_W{1'b1}};

    corr_state_e      state_q, state_d;
    logic [SEL_W-1:0] sel_q;
    logic [SEL_N-1:0] strb_pad;
    logic             start, stop, win_last, measuring, cnt_inc;
    logic [RES_W-1:0] cnt_val, cnt_nxt;
    logic [RES_W-1:0] result_q;

    assign start     = sel_wr && (sel_code != SEL_OFF);
    assign stop      = sel_wr && (sel_code == SEL_OFF);
    assign measuring = (state_q == ST_MEASURE);
    assign strb_pad  = SEL_N'(sync_strb);
    assign cnt_inc   = measuring && strb_pad[sel_q];

    sc_sat_counter #(.W(RES_W)) i_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start),
        .inc     (cnt_inc),
        .val     (cnt_val),
        .val_nxt (cnt_nxt)
    );

    sc_window_timer #(.WIN_LOG2(WIN_LOG2)) i_window (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .run   (measuring),
        .tick  (tick_ref),
        .last  (win_last)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_MEASURE;
            end
            ST_MEASURE: begin
                if (start)         state_d = ST_MEASURE;
                else if (stop)     state_d = ST_IDLE;
                else if (win_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            sel_q    <= '0;
        end else if (start) begin
            result_q <= '0;
            sel_q    <= sel_code;
        end else if (measuring && !stop && win_last) begin
            result_q <= cnt_nxt;
        end
    end

    assign corr_value = result_q;

    // R4
    busy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        measuring |-> (corr_value == '0));

    // R3
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state_q == ST_MEASURE && corr_value == '0 && cnt_val == '0));

    // R6
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (measuring && stop) |=> (state_q == ST_IDLE && corr_value == '0));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!measuring && !start) |=> $stable(corr_value));
endmodule

// File: tb/test_sync_corr_counter.sv
module test_sync_corr_counter;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_DEC    = 3;
    localparam int SEL_W      = 2;
    localparam int WLOG       = 3;
    localparam int RES_W      = 5;
    localparam int WIN        = 1 << WLOG;
    localparam int MAXV       = (1 << RES_W) - 1;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               sel_wr;
    logic [SEL_W-1:0]   sel_code;
    logic               tick_ref;
    logic [NUM_DEC-1:0] sync_strb;
    logic [RES_W-1:0]   corr_value;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sync_corr_counter #(
        .NUM_DEC(NUM_DEC), .SEL_W(SEL_W), .WIN_LOG2(WLOG), .RES_W(RES_W)
    ) i_sync_corr_counter (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_code(sel_code),
        .tick_ref(tick_ref), .sync_strb(sync_strb), .corr_value(corr_value)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: corr_value=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the next negedge
    task automatic step(input bit t, input logic [NUM_DEC-1:0] s,
                        input bit wr, input logic [SEL_W-1:0] code);
        tick_ref  = t;
        sync_strb = s;
        sel_wr    = wr;
        sel_code  = code;
        @(posedge clk);
        @(negedge clk);
        tick_ref  = 1'b0;
        sync_strb = '0;
        sel_wr    = 1'b0;
    endtask

    function automatic logic [NUM_DEC-1:0] pattern(input int c, input int seed);
        logic [NUM_DEC-1:0] s;
        for (int d = 0; d < NUM_DEC; d++) s[d] = ((c + seed) % (d + 2)) == 0;
        return s;
    endfunction

    task automatic run_window(input int sel, input int period, input int seed, input bit all_on);
        int exp = 0;
        int ticks = 0;
        int c = 0;
        step(1'b0, '1, 1'b1, SEL_W'(sel));  // strobe in write cycle ignored (R10)
        check("R3", corr_value, 0);
        while (ticks < WIN) begin
            logic t;
            logic [NUM_DEC-1:0] s;
            t = (c % period) == period - 1;
            s = all_on ? '1 : pattern(c, seed);
            if (s[sel]) exp = (exp == MAXV) ? MAXV : exp + 1;
            step(t, s, 1'b0, '0);
            if (t) ticks++;
            if (ticks < WIN) check("R4", corr_value, 0);
            c++;
        end
        check(all_on ? "R9" : "R1/R2", corr_value, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: corr_value=%0d expected=finish", corr_value);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; sel_wr = 1'b0; sel_code = '0; tick_ref = 1'b0; sync_strb = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R5", corr_value, 0);
        step(1'b1, '1, 1'b0, '0);
        check("R5", corr_value, 0);

        // sweep over decoder, tick spacing and strobe phase (R1, R2)
        for (int sel = 0; sel < NUM_DEC; sel++)
            for (int p = 1; p <= 4; p++)
                for (int sd = 0; sd < 3; sd++)
                    run_window(sel, p, sd, 1'b0);

        // saturation: strobe every cycle, 5 cycles per tick -> 40 strobes (R9)
        run_window(1, 5, 0, 1'b1);
        // no saturation with 8 strobes
        run_window(2, 1, 0, 1'b1);
        check("R1", corr_value, WIN);

        // R8: idle disable write, ticks and strobes leave result
        for (int i = 0; i < 6; i++) step(1'b1, '1, (i == 2), 2'b11);
        check("R8", corr_value, WIN);

        // R10: only strobe on final tick cycle
        step(1'b0, '0, 1'b1, 2'd0);
        for (int i = 0; i < WIN; i++) step(1'b1, (i == WIN - 1) ? 3'b001 : 3'b000, 1'b0, '0);
        check("R10", corr_value, 1);

        // R7: restart after 5 ticks of strobes; count only after restart
        step(1'b0, '0, 1'b1, 2'd1);
        for (int i = 0; i < 5; i++) step(1'b1, 3'b010, 1'b0, '0);
        step(1'b1, 3'b010, 1'b1, 2'd2);   // restart; this tick and strobe discarded
        check("R7", corr_value, 0);
        for (int i = 0; i < WIN - 1; i++) step(1'b1, 3'b100, 1'b0, '0);
        check("R7", corr_value, 0);
        step(1'b1, 3'b000, 1'b0, '0);
        check("R7", corr_value, WIN - 1);

        // R6: abort mid-window, then ticks and strobes never update
        step(1'b0, '0, 1'b1, 2'd0);
        for (int i = 0; i < 3; i++) step(1'b1, '1, 1'b0, '0);
        step(1'b0, '1, 1'b1, 2'b11);
        check("R6", corr_value, 0);
        for (int i = 0; i < 2 * WIN; i++) step(1'b1, '1, 1'b0, '0);
        check("R6", corr_value, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule